// File: doc/BRIEF.md
# Cascadable Serial Segment Data Loader

This block collects display segment bits from a slow serial link and presents them as a parallel segment vector. A serial data bit is taken into a shift register at each falling edge of an active-low data clock, but only while the active-low select input is low. A load strobe then copies the shift register into a parallel segment register. That register is level sensitive: while the strobe is high and select is low, it follows the shift register. When the strobe is low, it holds its value. A stored 1 marks the matching segment as active.

Three cascade taps come from the shift register. They are taken from stages 30, 32 and 38 and are updated on the rising edge of the data clock, half a data-clock cycle after the shift. The next device in a chain can therefore sample its input on its own falling edge. The data clock, data, select and strobe are asynchronous to the block. They pass through synchronizer chains and their edges are detected in the single system clock domain.

Stage 1 is the first stage loaded. `seg_q[k-1]` holds stage k. After 38 shifts, the first bit sent has reached stage 38.

Top module: `seg_serial_loader`

## Requirements
- R1: After reset, `seg_q` is all zeros and the three taps are 0.
- R2: At each falling edge of `dclk_n` while `sel_n` is low, `sdin` enters stage 1 and every stage k moves to stage k+1. After 38 such edges, the first bit sent sits in stage 38.
- R3: Falling edges of `dclk_n` while `sel_n` is high do not change the shift register.
- R4: While `load` is high and `sel_n` is low, `seg_q` follows the shift register, including shifts made during the pulse. `seg_q[k-1]` is stage k.
- R5: While `load` is low, `seg_q` holds its value, whatever shifting takes place.
- R6: A `load` pulse while `sel_n` is high leaves `seg_q` unchanged.
- R7: `tap_30`, `tap_32` and `tap_38` present stages 30, 32 and 38 respectively.
- R8: The taps change only at a rising edge of `dclk_n`. After a falling edge they keep their previous value until the next rising edge.
- R9: Rising edges of `dclk_n` never shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdin | input | 1 | Serial segment data |
| dclk_n | input | 1 | Data clock; data is sampled on its falling edge |
| sel_n | input | 1 | Active-low select |
| load | input | 1 | Active-high, level-sensitive load strobe |
| seg_q | output | 38 | Latched segment bits; bit k-1 is stage k |
| tap_30 | output | 1 | Cascade tap from stage 30 |
| tap_32 | output | 1 | Cascade tap from stage 32 |
| tap_38 | output | 1 | Cascade tap from the last stage |

## Verification
The bench builds the block with its defaults: 38 stages, taps at 30 and 32, and two-flop synchronizers. With these values, full random frames of 38 bits reach every tap and every segment position, and each frame is compared against a bench shift model. Directed sequences check the following:
- deselected shifting and deselected strobes have no effect;
- the segment register holds while the strobe is low;
- the segment register is transparent when bits are shifted during a long strobe;
- the taps stay put between a falling edge and the following rising edge.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
   // Checks that a tap position lies inside the shift register.
   function automatic bit tap_in_range(input int pos, input int stages);
      return (pos >= 1) && (pos <= stages);
   endfunction
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
   parameter int WIDTH = 1,
   parameter int DEPTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sig_sync: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] chain [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[DEPTH-1];
endmodule

// File: rtl/seg_shifter.sv
module seg_shifter #(
   parameter int STAGES = 38,
   parameter int TAP_A  = 30,
   parameter int TAP_B  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              rise,
   input  logic              sel_n_s,
   input  logic              din_s,
   output logic [STAGES-1:0] sr,
   output logic              tap_a,
   output logic              tap_b,
   output logic              tap_end
);
   import seg_loader_pkg::*;

   if (!tap_in_range(TAP_A, STAGES) || !tap_in_range(TAP_B, STAGES)) begin : g_bad_tap
      $error("seg_shifter: tap position outside the register");
   end
   if (STAGES < 2) begin : g_bad_len
      $error("seg_shifter: STAGES must be at least 2");
   end

   // Stage 1 is sr[0]; the oldest bit moves toward sr[STAGES-1].
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else if (fall && !sel_n_s) sr <= {sr[STAGES-2:0], din_s};
   end

   // Taps follow the register only on the opposite data-clock edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_a   <= 1'b0;
         tap_b   <= 1'b0;
         tap_end <= 1'b0;
      end else if (rise) begin
         tap_a   <= sr[TAP_A-1];
         tap_b   <= sr[TAP_B-1];
         tap_end <= sr[STAGES-1];
      end
   end

   assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !sel_n_s) |=> (sr[0] == $past(din_s)) && (sr[STAGES-1:1] == $past(sr[STAGES-2:0])));
   assert_desel_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_s |=> $stable(sr));
   assert_rise_no_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !fall) |=> $stable(sr));
   assert_tap_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable({tap_a, tap_b, tap_end}));
endmodule

// File: rtl/seg_hold.sv
module seg_hold #(
   parameter int STAGES = 38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_s,
   input  logic              sel_n_s,
   input  logic [STAGES-1:0] sr,
   output logic [STAGES-1:0] seg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg <= '0;
      else if (load_s && !sel_n_s) seg <= sr;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (seg == '0));
   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_s |=> $stable(seg));
   assert_desel_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_s |=> $stable(seg));
   assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s && !sel_n_s) |=> (seg == $past(sr)));
endmodule

// File: rtl/seg_serial_loader.sv
module seg_serial_loader #(
   parameter int STAGES      = 38,
   parameter int TAP_A       = 30,
   parameter int TAP_B       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdin,
   input  logic              dclk_n,
   input  logic              sel_n,
   input  logic              load,
   output logic [STAGES-1:0] seg_q,
   output logic              tap_30,
   output logic              tap_32,
   output logic              tap_38
);
   // Bundle order: {dclk_n, sel_n, load, sdin}; idle clock high, deselected.
   localparam logic [3:0] SYNC_RST = 4'b1100;

   logic [3:0]        raw_in, syn_in;
   logic              dclk_s, sel_n_s, load_s, din_s, dclk_prev;
   logic              fall, rise;
   logic [STAGES-1:0] sr;

   assign raw_in = {dclk_n, sel_n, load, sdin};

   sig_sync #(.WIDTH(4), .DEPTH(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

   assign {dclk_s, sel_n_s, load_s, din_s} = syn_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dclk_prev <= 1'b1;
      else dclk_prev <= dclk_s;
   end

   assign fall = dclk_prev & ~dclk_s;
   assign rise = ~dclk_prev & dclk_s;

   seg_shifter #(.STAGES(STAGES), .TAP_A(TAP_A), .TAP_B(TAP_B)) shift_i (
      .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .sel_n_s(sel_n_s),
      .din_s(din_s), .sr(sr), .tap_a(tap_30), .tap_b(tap_32), .tap_end(tap_38));

   seg_hold #(.STAGES(STAGES)) hold_i (
      .clk(clk), .rst_n(rst_n), .load_s(load_s), .sel_n_s(sel_n_s),
      .sr(sr), .seg(seg_q));
endmodule

// File: tb/seg_serial_loader_tb_top.sv
module seg_serial_loader_tb_top;
   localparam int N = 38;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sdin = 1'b0, dclk_n = 1'b1, sel_n = 1'b1, load = 1'b0;
   logic [N-1:0] seg_q;
   logic tap_30, tap_32, tap_38;

   int checks = 0, errors = 0;
   logic [N-1:0] model = '0;   // bench shift model, model[0] = stage 1
   logic [N-1:0] seg_exp = '0;
   logic [2:0]   tap_exp = '0; // {t30, t32, t38}

   always #2 clk = ~clk;

   seg_serial_loader dut_i (.clk(clk), .rst_n(rst_n), .sdin(sdin), .dclk_n(dclk_n),
      .sel_n(sel_n), .load(load), .seg_q(seg_q), .tap_30(tap_30), .tap_32(tap_32),
      .tap_38(tap_38));

   function automatic logic [2:0] taps_of(input logic [N-1:0] m);
      return {m[29], m[31], m[N-1]};
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s seg act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_taps(input string req);
      checks++;
      if ({tap_30, tap_32, tap_38} !== tap_exp) begin
         errors++;
         $display("FAIL %s taps act=%b exp=%b", req, {tap_30, tap_32, tap_38}, tap_exp);
      end
   endtask

   // One data-clock period; optional check of R8 between the two edges.
   task automatic send_bit(input logic b, input bit mid_check);
      sdin = b;
      wait_clk(4);
      dclk_n = 1'b0;
      wait_clk(6);
      if (!sel_n) model = {model[N-2:0], b};
      if (mid_check) check_taps("R8 taps before rising edge");
      dclk_n = 1'b1;
      wait_clk(6);
      tap_exp = taps_of(model);
   endtask

   task automatic pulse_load(input int width);
      load = 1'b1;
      wait_clk(width);
      load = 1'b0;
      wait_clk(6);
      if (!sel_n) seg_exp = model;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      wait_clk(5);
      check_vec("R1 reset seg", seg_q, '0);
      check_taps("R1 reset taps");
      rst_n = 1'b1;
      wait_clk(6);
      check_vec("R1 after release", seg_q, '0);

      // Directed: a single 1 walks to stage 38 after 38 edges (R2, R7).
      sel_n = 1'b0;
      wait_clk(4);
      send_bit(1'b1, 1'b1);
      for (int i = 1; i < N; i++) send_bit(1'b0, 1'b1);
      check_taps("R2 R7 first bit at stage 38");
      pulse_load(6);
      check_vec("R2 R4 walking one", seg_q, seg_exp);

      // Random frames.
      for (int f = 0; f < 5; f++) begin
         for (int i = 0; i < N; i++) send_bit(1'($urandom), (i % 7) == 0);
         check_taps("R7 random taps");
         check_vec("R5 hold before load", seg_q, seg_exp);
         pulse_load(4 + f);
         check_vec("R4 random load", seg_q, seg_exp);
      end

      // Hold while load is low.
      for (int i = 0; i < 5; i++) send_bit(1'($urandom), 1'b0);
      check_vec("R5 hold during shifting", seg_q, seg_exp);

      // Deselected shifting and load.
      sel_n = 1'b1;
      wait_clk(4);
      for (int i = 0; i < 6; i++) send_bit(~model[0], 1'b0);
      check_taps("R3 taps with select high");
      pulse_load(6);
      check_vec("R6 load ignored when deselected", seg_q, seg_exp);
      sel_n = 1'b0;
      wait_clk(4);
      pulse_load(6);
      check_vec("R3 register unchanged by deselected edges", seg_q, seg_exp);

      // Transparency: shift while load is held high.
      load = 1'b1;
      wait_clk(6);
      for (int i = 0; i < 4; i++) begin
         send_bit(1'($urandom), 1'b0);
         check_vec("R4 transparent follow", seg_q, model);
      end
      load = 1'b0;
      wait_clk(6);
      seg_exp = model;
      send_bit(~model[0], 1'b0);
      check_vec("R5 hold after strobe drop", seg_q, seg_exp);

      // Rising edge alone does not shift: repeated clock high, then reload.
      sdin = 1'b1;
      dclk_n = 1'b1;
      wait_clk(10);
      pulse_load(6);
      check_vec("R9 no shift on rising", seg_q, seg_exp);
      check_taps("R9 taps steady");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule